// File: doc/BRIEF.md
# Single-Channel Bus-Stealing DMA Controller

This block moves a block of bytes between one peripheral and memory without the processor copying them. Software programs a start address, a byte count and a control word through a small write port. Setting the go bit arms the channel. When the peripheral raises its request, the controller asks the processor for the system bus with an active-high hold line. Once the hold acknowledge comes back, it drives the memory address and pulses an acknowledge to the peripheral. The data goes straight between the peripheral and memory, and the controller issues only the memory strobe that matches the direction.

In single-byte mode the bus is taken and given back for every byte. In burst mode it is kept until the whole block has moved. After each byte the address goes up by one and the count goes down by one. When the count is exhausted the controller raises an interrupt, which stays set until software clears it.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After a synchronous active-low reset, hold, acknowledge, bus enable, both memory strobes, busy and the interrupt are all low.
- R2: Register select 2 is the control word: bit 0 is direction, bit 1 is burst, bit 2 is go. An armed channel raises hold only after the peripheral request is seen. Acknowledge and bus enable are asserted only while both hold and the hold acknowledge input are high.
- R3: Direction 0 moves a byte from the peripheral to memory, so each byte pulses the memory write strobe. Direction 1 moves a byte from memory to the peripheral, so each byte pulses the memory read strobe. The two strobes are never high together, and neither is high without the acknowledge.
- R4: In single-byte mode, hold drops in the cycle after each byte. Hold is not raised again until the hold acknowledge input has been seen low.
- R5: Register select 0 holds the start address and select 1 holds the byte count. Bytes go to consecutive addresses starting at the start address, wrapping modulo the address width. Exactly count bytes move.
- R6: In burst mode, hold stays high from the grant through the last byte and is raised once per block. While the bus is held, one byte moves in each cycle that the peripheral request is high. In single-byte mode, the byte moves in the first granted cycle.
- R7: The interrupt rises when the last byte's bus release has been acknowledged. It stays high until a write to select 3 with bit 0 set clears it.
- R8: While a block is in progress, writes to selects 0, 1 and 2 are ignored: the running block keeps its address, count, direction and mode, and go does not restart it.
- R9: Starting with a count of zero takes no bus. The interrupt is high in the cycle after the go write, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status clear |
| cfg_wdata | input | ADDR_W | Register write data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to the peripheral, one byte per high cycle |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| bus_en | output | 1 | Controller owns and drives the bus |
| mem_addr | output | ADDR_W | Memory address of the current byte |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| busy | output | 1 | A block is armed or moving |
| irq | output | 1 | Block-complete interrupt |

## Verification
Every result is one register stage from its cause. Hold rises one edge after the request is seen in the armed state. The acknowledge and strobe appear one edge after the grant is sampled. Hold drops one edge after a single-mode byte, and the interrupt rises on the same edge that sees the grant released after the last byte. A zero-count go shows its interrupt one edge after the write. The bench drives all inputs on the falling edge and reads the outputs there, half a period after the edge that produced them. Its bus model answers hold on the following falling edge, optionally holding the grant a few cycles longer, so each grant and release lands on a known edge.

// File: rtl/dma_steal_pkg.sv
// Package: shared encodings for the bus-stealing DMA controller.
// Assumes the register select is two bits wide and the control word fits the low bits.
package dma_steal_pkg;

    // Register selects on the configuration write port
    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    // Bit positions inside the control word
    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_BURST_BIT = 1;
    localparam int CTRL_GO_BIT    = 2;

    // Bit position inside the status clear word
    localparam int STAT_CLR_BIT = 0;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_REQ   = 3'd2,
        ST_XFER  = 3'd3,
        ST_REL   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: configuration registers of the DMA channel.
// Holds the staged start address, byte count, direction and mode. Produces a
// one-cycle start pulse and an interrupt clear pulse.
// Assumes: writes other than the status clear are accepted only while idle.
module dma_cfg_regs
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  base_cnt,
    output logic              dir,
    output logic              burst,
    output logic              start,
    output logic              start_zero,
    output logic              clr_irq
);

    logic wr_addr;
    logic wr_cnt;
    logic wr_ctrl;

    // Decode writes; the busy-time lockout applies to all but the status clear
    always_comb begin
        wr_addr = we && idle && (sel == SEL_ADDR);
        wr_cnt  = we && idle && (sel == SEL_COUNT);
        wr_ctrl = we && idle && (sel == SEL_CTRL);
        clr_irq = we && (sel == SEL_STATUS) && wdata[STAT_CLR_BIT];
    end

    // Staged start address
    always_ff @(posedge clk) begin
        if (!rst_n)       base_addr <= '0;
        else if (wr_addr) base_addr <= wdata;
    end

    // Staged byte count
    always_ff @(posedge clk) begin
        if (!rst_n)      base_cnt <= '0;
        else if (wr_cnt) base_cnt <= wdata[CNT_W-1:0];
    end

    // Direction and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= 1'b0;
            burst <= 1'b0;
        end else if (wr_ctrl) begin
            dir   <= wdata[CTRL_DIR_BIT];
            burst <= wdata[CTRL_BURST_BIT];
        end
    end

    // Start pulse and the zero-length flag that travels with it
    always_comb begin
        start      = wr_ctrl && wdata[CTRL_GO_BIT];
        start_zero = (base_cnt == '0);
    end

endmodule

// File: rtl/dma_xfer_ctr.sv
// Module: working address and remaining-count registers of the channel.
// Loads from the staged values on start. Each moved byte steps the address up
// and the count down.
// Assumes: step is never asserted while the count is zero.
module dma_xfer_ctr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              cnt_last,
    output logic              cnt_zero
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Address register: load on start, increment per byte, wrap naturally
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_addr;
        else if (step) addr <= addr + ADDR_ONE;
    end

    // Remaining-count register: load on start, decrement per byte
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_cnt;
        else if (step) cnt_q <= cnt_q - CNT_ONE;
    end

    // Count status flags for the sequencer
    always_comb begin
        cnt_last = (cnt_q == CNT_ONE);
        cnt_zero = (cnt_q == '0);
    end

endmodule

// File: rtl/dma_seq_fsm.sv
// Module: bus-stealing sequencer.
// Waits for a peripheral request, asks for the bus, moves bytes once granted,
// and releases the bus after each byte (single) or after the block (burst).
// Raises the completion interrupt.
// Assumes: the grant is not withdrawn while hold is high.
module dma_seq_fsm
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_zero,
    input  logic burst,
    input  logic dreq,
    input  logic hlda,
    input  logic cnt_last,
    input  logic cnt_zero,
    input  logic clr_irq,
    output logic step,
    output logic hold,
    output logic bus_en,
    output logic busy,
    output logic idle,
    output logic irq
);

    seq_state_t st_q;
    seq_state_t st_d;
    logic       irq_set;

    // Next-state, byte-step and interrupt-set decision
    always_comb begin
        st_d    = st_q;
        step    = 1'b0;
        irq_set = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (start_zero) irq_set = 1'b1;
                    else            st_d    = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (dreq) st_d = ST_REQ;
            end
            ST_REQ: begin
                if (hlda) st_d = ST_XFER;
            end
            ST_XFER: begin
                step = burst ? dreq : 1'b1;
                if (step && (cnt_last || !burst)) st_d = ST_REL;
            end
            ST_REL: begin
                if (!hlda) begin
                    if (cnt_zero) begin
                        st_d    = ST_IDLE;
                        irq_set = 1'b1;
                    end else begin
                        st_d = ST_ARMED;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Completion interrupt: set has priority over a coincident clear
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (clr_irq) irq <= 1'b0;
    end

    // Bus-side outputs decoded from the state
    always_comb begin
        hold   = (st_q == ST_REQ) || (st_q == ST_XFER);
        bus_en = (st_q == ST_XFER);
        busy   = (st_q != ST_IDLE);
        idle   = (st_q == ST_IDLE);
    end

endmodule

// File: rtl/dma_steal_ctrl.sv
// Module: top of the single-channel bus-stealing DMA controller.
// Connects the configuration registers, the working counters and the
// sequencer. Turns each byte step into the acknowledge and the strobe for the
// chosen direction. Data moves fly-by between the peripheral and memory.
// Assumes: CNT_W does not exceed ADDR_W, as the count shares the write bus.
module dma_steal_ctrl
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hold,
    input  logic              hlda,
    output logic              bus_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              busy,
    output logic              irq
);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    logic              cfg_dir;
    logic              cfg_burst;
    logic              start;
    logic              start_zero;
    logic              clr_irq;
    logic              idle;
    logic              step;
    logic              cnt_last;
    logic              cnt_zero;
    logic              load;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .base_addr  (base_addr),
        .base_cnt   (base_cnt),
        .dir        (cfg_dir),
        .burst      (cfg_burst),
        .start      (start),
        .start_zero (start_zero),
        .clr_irq    (clr_irq)
    );

    // Counters load only for a non-empty block
    always_comb load = start && !start_zero;

    dma_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .load_addr (base_addr),
        .load_cnt  (base_cnt),
        .addr      (mem_addr),
        .cnt_last  (cnt_last),
        .cnt_zero  (cnt_zero)
    );

    dma_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_zero (start_zero),
        .burst      (cfg_burst),
        .dreq       (dreq),
        .hlda       (hlda),
        .cnt_last   (cnt_last),
        .cnt_zero   (cnt_zero),
        .clr_irq    (clr_irq),
        .step       (step),
        .hold       (hold),
        .bus_en     (bus_en),
        .busy       (busy),
        .idle       (idle),
        .irq        (irq)
    );

    // Per-byte acknowledge and direction-selected memory strobe
    always_comb begin
        dack   = step;
        mem_wr = step && !cfg_dir;
        mem_rd = step && cfg_dir;
    end

endmodule

// File: rtl/dma_steal_chk.sv
// Module: property checker for the DMA controller, bound to the top.
// Watches the bus handshake, strobes, address stepping and interrupt timing.
// Assumes: burst_mode and last_byte come from the top's internal nets.
module dma_steal_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dack,
    input logic              hold,
    input logic              hlda,
    input logic              bus_en,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              irq,
    input logic              burst_mode,
    input logic              last_byte
);

    assert_ack_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dack || bus_en) |-> (hold && hlda));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (dack && (mem_wr != mem_rd)));

    assert_single_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !burst_mode) |=> !hold);

    assert_regrant_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !$past(hlda));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> (mem_addr == $past(mem_addr) + 1'b1));

    assert_burst_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && burst_mode && !last_byte) |=> hold);

    assert_irq_at_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!hold && !busy));

endmodule

bind dma_steal_ctrl dma_steal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dack       (dack),
    .hold       (hold),
    .hlda       (hlda),
    .bus_en     (bus_en),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .irq        (irq),
    .burst_mode (cfg_burst),
    .last_byte  (cnt_last)
);

// File: tb/tb_dma_steal_ctrl.sv
// Bench for the bus-stealing DMA controller: a vector table of blocks walked by
// one loop, then directed tests for reset, zero count and locked registers.
module tb_dma_steal_ctrl;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dreq = 1'b0;
    logic          hlda = 1'b0;
    logic          dack, hold, bus_en, mem_wr, mem_rd, busy, irq;
    logic [AW-1:0] mem_addr;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    dma_steal_ctrl #(.ADDR_W(AW), .CNT_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .hold(hold),
        .hlda(hlda), .bus_en(bus_en), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .busy(busy), .irq(irq)
    );

    // Vector: {start address, count, dir, burst, stall dreq, grant lag}
    localparam int VN = 5;
    localparam logic [36:0] VEC [VN] = '{
        {16'h1000, 16'd3, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'h20FE, 16'd4, 1'b1, 1'b0, 1'b0, 2'd2},
        {16'h0300, 16'd5, 1'b0, 1'b1, 1'b0, 2'd0},
        {16'hFFFE, 16'd4, 1'b1, 1'b1, 1'b1, 2'd0},
        {16'h4000, 16'd1, 1'b0, 1'b1, 1'b0, 2'd1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [AW-1:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_block(input logic [AW-1:0] a, input logic [AW-1:0] c,
                               input bit dir, input bit burst);
        cpu_write(2'd0, a);
        cpu_write(2'd1, c);
        cpu_write(2'd2, AW'({1'b1, burst, dir}));
    endtask

    // Acts as peripheral and bus arbiter until the interrupt, checking each byte
    task automatic follow_block(input logic [AW-1:0] a, input logic [AW-1:0] c,
                                input bit dir, input bit burst, input bit stall,
                                input int lag);
        logic [AW-1:0] exp_a = a;
        int  nbytes = 0;
        int  grants = 0;
        int  lc = 0;
        bit  prev_hold = 1'b0;
        bit  prev_dack = 1'b0;
        bit  seen_irq = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (dack) begin
                check(mem_addr == exp_a, "R5", "byte address", mem_addr, exp_a);
                check(dir ? (mem_rd && !mem_wr) : (mem_wr && !mem_rd), "R3",
                      "strobe {wr,rd}", {mem_wr, mem_rd}, dir ? 1 : 2);
                exp_a++;
                nbytes++;
            end
            if (hold && !prev_hold) begin
                grants++;
                if (hlda) check(1'b0, "R4", "hold raised before grant dropped", 1, 0);
            end
            if (!burst && prev_dack && hold)
                check(1'b0, "R4", "hold kept after single byte", 1, 0);
            if (irq) begin
                seen_irq = 1'b1;
                break;
            end
            prev_hold = hold;
            prev_dack = dack;
            dreq = stall ? ((cyc % 3) != 2) : 1'b1;
            if (hold) begin
                hlda = 1'b1;
                lc   = lag;
            end else if (lc > 0) begin
                lc--;
            end else begin
                hlda = 1'b0;
            end
            @(negedge clk);
        end
        dreq = 1'b0;
        hlda = 1'b0;
        check(seen_irq, "R7", "interrupt at end of block", seen_irq, 1);
        check(nbytes == int'(c), "R5", "bytes moved", nbytes, c);
        check(grants == (burst ? 1 : int'(c)), burst ? "R6" : "R4",
              "bus grants per block", grants, burst ? 1 : c);
        check(!busy && !hold, "R7", "idle after completion {busy,hold}",
              {busy, hold}, 0);
        @(negedge clk);
        check(irq == 1'b1, "R7", "interrupt held until cleared", irq, 1);
        cpu_write(2'd3, 16'h0001);
        check(irq == 1'b0, "R7", "interrupt cleared by status write", irq, 0);
    endtask

    initial begin
        #200us;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({hold, dack, bus_en, mem_wr, mem_rd, busy, irq} == 7'b0, "R1",
              "outputs in reset", {hold, dack, bus_en, mem_wr, mem_rd, busy, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({hold, dack, bus_en, busy, irq} == 5'b0, "R1",
              "outputs after reset", {hold, dack, bus_en, busy, irq}, 0);

        // Table of blocks (R2 R3 R4 R5 R6 R7)
        for (int v = 0; v < VN; v++) begin
            logic [36:0] e = VEC[v];
            start_block(e[36:21], e[20:5], e[4], e[3]);
            follow_block(e[36:21], e[20:5], e[4], e[3], e[2], int'(e[1:0]));
        end

        // R9: zero count completes at once without the bus
        start_block(16'h1234, 16'd0, 1'b0, 1'b0);
        check(irq == 1'b1, "R9", "interrupt one cycle after go", irq, 1);
        check({hold, busy} == 2'b00, "R9", "no bus and not busy", {hold, busy}, 0);
        cpu_write(2'd3, 16'h0001);
        check(irq == 1'b0, "R7", "zero-count interrupt cleared", irq, 0);

        // R2 and R8: armed channel waits for request; writes while busy ignored
        start_block(16'h5000, 16'd2, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(busy && !hold, "R2", "armed without request {busy,hold}",
              {busy, hold}, 2);
        cpu_write(2'd0, 16'h7777);
        cpu_write(2'd1, 16'd9);
        cpu_write(2'd2, 16'h0007);
        check(busy && !hold, "R8", "locked writes leave channel armed",
              {busy, hold}, 2);
        follow_block(16'h5000, 16'd2, 1'b0, 1'b0, 1'b0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule